// File: doc/BRIEF.md
# Z80 Bus Memory Window Slave

This block sits on a Z80 expansion bus and can take over a fixed 16 KB memory window at 0x8000 to 0xBFFF. Three I/O port writes choose how it behaves: switched off, backed by a RAM-disk byte store, or backed by a separate mapped-I/O byte store. When a mode is active, any memory read or write that lands inside the window is answered from the chosen store. The block also raises a RAM-disable output so the base memory neither drives the data lines nor accepts the write.

The bus strobes are sampled on a fast system clock, which must run at least eight times the bus clock. They pass through a two-flop synchronizer, and per-cycle flags make sure that each bus cycle causes exactly one store access. The data bus is split into an input, an output and an output-enable, so the pad can tri-state it. A host-side port running on the fast clock reads and writes the mapped-I/O store, so a local processor can exchange data with the bus master.

Top module: `z80win`

## Requirements
- R1: After reset the block is unmapped: `ramdis_o` low, `data_oe_o` low, and no window cycle is claimed until a mode port is written.
- R2: Only addresses 0x8000 to 0xBFFF are claimed. Reads at 0x7FFF or 0xC000 are not driven, and writes there leave both stores unchanged.
- R3: In unmapped mode no memory cycle is claimed: `ramdis_o` stays low, the data bus is never driven and no store is written.
- R4: `ramdis_o` is high, decoded directly from the bus pins, exactly when a mode is active, the address is in the window, `mreq_ni` is low and either `rd_ni` or `wr_ni` is low.
- R5: On a claimed read, `data_oe_o` rises no later than 4 clocks after RD and MREQ are both low. It falls no later than 4 clocks after RD or MREQ rises. While it is high, `data_o` holds the addressed byte unchanged.
- R6: An I/O write cycle (`iorq_ni` and `wr_ni` low) selects unmapped mode at port 0x0001, RAM-disk mode at 0x0002 and mapped-I/O mode at 0x0003, compared on all 16 address bits. Any other port, and any I/O read cycle, leaves the mode unchanged.
- R7: A claimed write stores the data byte present when the block first sees the strobe. It writes exactly once per bus cycle, so later changes of `data_i` in the same cycle have no effect.
- R8: RAM-disk mode uses only the RAM-disk store and mapped-I/O mode uses only the I/O store. A byte written in one mode is not seen through the other.
- R9: The host port writes the I/O store when `host_we_i` is high. `host_rdata_o` gives the byte at `host_addr_i` one clock later, and the host port never reaches the RAM-disk store.
- R10: While a claimed bus write to the I/O store is in progress, host writes are dropped, so the bus value wins at the shared location.
- R11: Each store is indexed by address bits STORE_AW-1:0, so window addresses that differ only above those bits alias to the same byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast system clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 16 | Bus address |
| data_i | input | 8 | Bus data in |
| data_o | output | 8 | Bus data out |
| data_oe_o | output | 1 | Bus data output enable |
| mreq_ni | input | 1 | Memory request, active low |
| iorq_ni | input | 1 | I/O request, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| ramdis_o | output | 1 | Base RAM disable |
| host_we_i | input | 1 | Host write enable to the I/O store |
| host_addr_i | input | STORE_AW | Host byte index |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 8 | Host read data, one clock latency |

## Verification
A wrong mode register shows at the ports on the very next window access. `ramdis_o` either stays low or rises when it should not, and this is compared on every clock. A stuck per-cycle flag shows up as a second store write, which the bench sees as the late data byte replacing the first one. A missing release shows as `data_oe_o` staying high more than four clocks after the strobe rises. Store cross-talk or a lost host write shows on the next bus or host read of that byte, because every read is compared against a behavioural model of both stores.

// File: rtl/z80win_pkg.sv
package z80win_pkg;
  typedef enum logic [1:0] {
    MODE_OFF     = 2'd0,
    MODE_RAMDISK = 2'd1,
    MODE_IOMAP   = 2'd2
  } mode_e;

  localparam int NUM_STORES = 2;
  localparam int ST_RAMDISK = 0;
  localparam int ST_IOMAP   = 1;
endpackage

// File: rtl/z80win_sync.sv
module z80win_sync #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  // strobes are active low: idle value is all ones
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '1;
      sync_q <= '1;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/z80win_store.sv
module z80win_store #(
  parameter int AW = 10
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/z80win_ctrl.sv
module z80win_ctrl import z80win_pkg::*; #(
  parameter logic [15:0] WIN_BASE     = 16'h8000,
  parameter int          WIN_AW       = 14,
  parameter logic [15:0] PORT_OFF     = 16'h0001,
  parameter logic [15:0] PORT_RAMDISK = 16'h0002,
  parameter logic [15:0] PORT_IOMAP   = 16'h0003
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [15:0] addr_i,
  input  logic        s_mreq_ni,
  input  logic        s_iorq_ni,
  input  logic        s_rd_ni,
  input  logic        s_wr_ni,
  output mode_e       mode_o,
  output logic        win_o,
  output logic        in_read_o,
  output logic        rd_start_o,
  output logic        rd_claim_o,
  output logic        wr_start_o,
  output logic        wr_claim_o
);
  mode_e mode_q;
  logic  in_read_q, in_write_q, in_io_q;
  logic  active, rd_req, wr_req, io_req, io_start;

  assign win_o  = addr_i[15:WIN_AW] == WIN_BASE[15:WIN_AW];
  assign active = mode_q != MODE_OFF;
  assign rd_req = active && win_o && !s_mreq_ni && !s_rd_ni;
  assign wr_req = active && win_o && !s_mreq_ni && !s_wr_ni;
  assign io_req = !s_iorq_ni && !s_wr_ni;

  assign rd_start_o = rd_req && !in_read_q;
  assign wr_start_o = wr_req && !in_write_q;
  assign io_start   = io_req && !in_io_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= MODE_OFF;
      in_read_q  <= 1'b0;
      in_write_q <= 1'b0;
      in_io_q    <= 1'b0;
    end else begin
      in_read_q  <= rd_req;
      in_write_q <= wr_req;
      in_io_q    <= io_req;
      if (io_start) begin
        if (addr_i == PORT_OFF)          mode_q <= MODE_OFF;
        else if (addr_i == PORT_RAMDISK) mode_q <= MODE_RAMDISK;
        else if (addr_i == PORT_IOMAP)   mode_q <= MODE_IOMAP;
      end
    end
  end

  assign mode_o     = mode_q;
  assign in_read_o  = in_read_q;
  assign rd_claim_o = rd_req;
  assign wr_claim_o = wr_req;
endmodule

// File: rtl/z80win.sv
module z80win import z80win_pkg::*; #(
  parameter int          STORE_AW     = 10,
  parameter logic [15:0] WIN_BASE     = 16'h8000,
  parameter int          WIN_AW       = 14,
  parameter logic [15:0] PORT_OFF     = 16'h0001,
  parameter logic [15:0] PORT_RAMDISK = 16'h0002,
  parameter logic [15:0] PORT_IOMAP   = 16'h0003
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [15:0]         addr_i,
  input  logic [7:0]          data_i,
  output logic [7:0]          data_o,
  output logic                data_oe_o,
  input  logic                mreq_ni,
  input  logic                iorq_ni,
  input  logic                rd_ni,
  input  logic                wr_ni,
  output logic                ramdis_o,
  input  logic                host_we_i,
  input  logic [STORE_AW-1:0] host_addr_i,
  input  logic [7:0]          host_wdata_i,
  output logic [7:0]          host_rdata_o
);
  localparam int SYNC_W = 4;

  logic [SYNC_W-1:0] strb_s;
  mode_e             mode_q;
  logic win, in_read, rd_start, rd_claim, wr_start, wr_claim;
  logic bus_sel, rd_claim_io, wr_claim_io;
  logic [STORE_AW-1:0] bus_idx;
  logic [7:0] data_q, host_rdata_q;

  logic                st_we    [NUM_STORES];
  logic [STORE_AW-1:0] st_waddr [NUM_STORES];
  logic [STORE_AW-1:0] st_raddr [NUM_STORES];
  logic [7:0]          st_wdata [NUM_STORES];
  logic [7:0]          st_rdata [NUM_STORES];

  z80win_sync #(.W(SYNC_W)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({mreq_ni, iorq_ni, rd_ni, wr_ni}),
    .q_o    (strb_s)
  );

  z80win_ctrl #(
    .WIN_BASE(WIN_BASE), .WIN_AW(WIN_AW), .PORT_OFF(PORT_OFF),
    .PORT_RAMDISK(PORT_RAMDISK), .PORT_IOMAP(PORT_IOMAP)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (addr_i),
    .s_mreq_ni  (strb_s[3]),
    .s_iorq_ni  (strb_s[2]),
    .s_rd_ni    (strb_s[1]),
    .s_wr_ni    (strb_s[0]),
    .mode_o     (mode_q),
    .win_o      (win),
    .in_read_o  (in_read),
    .rd_start_o (rd_start),
    .rd_claim_o (rd_claim),
    .wr_start_o (wr_start),
    .wr_claim_o (wr_claim)
  );

  assign bus_idx     = addr_i[STORE_AW-1:0];
  assign bus_sel     = mode_q == MODE_IOMAP;
  assign rd_claim_io = rd_claim && bus_sel;
  assign wr_claim_io = wr_claim && bus_sel;

  for (genvar g = 0; g < NUM_STORES; g++) begin : g_store
    logic bus_wr, host_wr;
    assign bus_wr  = wr_start && (int'(bus_sel) == g);
    // bus write strobe in progress blocks the host
    assign host_wr = (g == ST_IOMAP) && host_we_i && !wr_claim_io;
    assign st_we[g]    = bus_wr || host_wr;
    assign st_waddr[g] = bus_wr ? bus_idx : host_addr_i;
    assign st_wdata[g] = bus_wr ? data_i : host_wdata_i;
    assign st_raddr[g] = ((g == ST_IOMAP) && !rd_claim_io) ? host_addr_i : bus_idx;

    z80win_store #(.AW(STORE_AW)) u_store (
      .clk_i   (clk_i),
      .we_i    (st_we[g]),
      .waddr_i (st_waddr[g]),
      .wdata_i (st_wdata[g]),
      .raddr_i (st_raddr[g]),
      .rdata_o (st_rdata[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q       <= '0;
      host_rdata_q <= '0;
    end else begin
      if (rd_start)     data_q       <= st_rdata[bus_sel];
      if (!rd_claim_io) host_rdata_q <= st_rdata[ST_IOMAP];
    end
  end

  // decoded from raw pins so the base RAM is disabled without sync delay
  assign ramdis_o     = (mode_q != MODE_OFF) && win && !mreq_ni && (!rd_ni || !wr_ni);
  assign data_o       = data_q;
  assign data_oe_o    = in_read;
  assign host_rdata_o = host_rdata_q;
endmodule

// File: rtl/z80win_chk.sv
module z80win_chk import z80win_pkg::*; (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rd_ni,
  input logic       mreq_ni,
  input logic       ramdis_o,
  input logic       data_oe_o,
  input logic [7:0] data_o,
  input mode_e      mode_i,
  input logic       wr_start_i
);
  AST_DRIVE_HIDES_RAM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o && !rd_ni && !mreq_ni |-> ramdis_o); // R4

  AST_DRIVE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o && $past(data_oe_o) |-> $stable(data_o)); // R5

  AST_DRIVE_IN_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(data_oe_o) |-> !mreq_ni && !rd_ni); // R5

  AST_ONE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_start_i |=> !wr_start_i); // R7

  AST_OFF_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == MODE_OFF && $past(mode_i == MODE_OFF) |-> !$rose(data_oe_o)); // R3
endmodule

bind z80win z80win_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rd_ni      (rd_ni),
  .mreq_ni    (mreq_ni),
  .ramdis_o   (ramdis_o),
  .data_oe_o  (data_oe_o),
  .data_o     (data_o),
  .mode_i     (mode_q),
  .wr_start_i (wr_start)
);

// File: tb/z80win_test.sv
module z80win_test;
  localparam int AW    = 10;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  dat = '0;
  logic mreq_n = 1'b1, iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic host_we = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] data_o, host_rdata;
  logic data_oe, ramdis;

  int checks = 0;
  int errors = 0;
  int mode_m = 0;  // 0 off, 1 ram-disk, 2 io-map
  byte unsigned ram_m [int];
  byte unsigned io_m  [int];

  z80win #(.STORE_AW(AW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .data_i(dat),
    .data_o(data_o), .data_oe_o(data_oe), .mreq_ni(mreq_n), .iorq_ni(iorq_n),
    .rd_ni(rd_n), .wr_ni(wr_n), .ramdis_o(ramdis), .host_we_i(host_we),
    .host_addr_i(host_addr), .host_wdata_i(host_wdata), .host_rdata_o(host_rdata)
  );

  always #10 clk = ~clk;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit in_win(logic [15:0] a);
    return a >= 16'h8000 && a <= 16'hBFFF;
  endfunction

  // R4 reference, compared on every clock
  always @(negedge clk) begin
    #5;
    if (rst_ni)
      check("R4 ramdis", ramdis,
            int'(mode_m != 0 && in_win(addr) && !mreq_n && (!rd_n || !wr_n)));
  end

  task automatic io_cycle(logic [15:0] port, bit is_wr);
    @(negedge clk);
    addr = port; iorq_n = 1'b0;
    if (is_wr) wr_n = 1'b0; else rd_n = 1'b0;
    repeat (8) @(negedge clk);
    iorq_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1;
    repeat (5) @(negedge clk);
    if (is_wr) begin
      if (port == 16'h0001) mode_m = 0;
      else if (port == 16'h0002) mode_m = 1;
      else if (port == 16'h0003) mode_m = 2;
    end
  endtask

  task automatic mem_wr(logic [15:0] a, logic [7:0] d, logic [7:0] d_late, bit collide);
    @(negedge clk);
    addr = a; dat = d; mreq_n = 1'b0; wr_n = 1'b0;
    repeat (4) @(negedge clk);
    dat = d_late;
    if (collide) begin
      host_we = 1'b1; host_addr = a[AW-1:0]; host_wdata = 8'h5A;
    end
    repeat (4) @(negedge clk);
    host_we = 1'b0;
    mreq_n = 1'b1; wr_n = 1'b1;
    repeat (5) @(negedge clk);
    if (mode_m == 1 && in_win(a)) ram_m[int'(a) % DEPTH] = d;
    if (mode_m == 2 && in_win(a)) io_m[int'(a) % DEPTH]  = d;
  endtask

  task automatic mem_rd(logic [15:0] a, string req);
    int exp_on, exp_d;
    exp_on = int'(mode_m != 0 && in_win(a));
    exp_d  = 0;
    if (mode_m == 1 && exp_on != 0) exp_d = int'(ram_m[int'(a) % DEPTH]);
    if (mode_m == 2 && exp_on != 0) exp_d = int'(io_m[int'(a) % DEPTH]);
    @(negedge clk);
    addr = a; mreq_n = 1'b0; rd_n = 1'b0;
    repeat (4) @(negedge clk);
    #5;
    check({req, " oe"}, int'(data_oe), exp_on);
    if (exp_on != 0) check({req, " data"}, int'(data_o), exp_d);
    repeat (4) @(negedge clk);
    mreq_n = 1'b1; rd_n = 1'b1;
    repeat (4) @(negedge clk);
    #5;
    check("R5 release", int'(data_oe), 0);
  endtask

  task automatic host_wr(logic [AW-1:0] a, logic [7:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
    io_m[int'(a)] = d;
  endtask

  task automatic host_rd(logic [AW-1:0] a, string req);
    @(negedge clk);
    host_addr = a;
    @(negedge clk);
    #5;
    check(req, int'(host_rdata), int'(io_m[int'(a)]));
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #5;
    check("R1 reset ramdis", int'(ramdis), 0);
    check("R1 reset oe", int'(data_oe), 0);
    mem_rd(16'h8000, "R1 R3 off read");
    mem_wr(16'h8000, 8'hAB, 8'hAB, 1'b0);        // R3 ignored, model unchanged

    io_cycle(16'h0002, 1'b0);                    // R6 io read: no change
    mem_rd(16'h8000, "R6 io read ignored");
    io_cycle(16'h0102, 1'b1);                    // R6 upper byte differs
    mem_rd(16'h8000, "R6 full decode");

    io_cycle(16'h0002, 1'b1);                    // ram-disk mode
    mem_wr(16'h8000, 8'h11, 8'h99, 1'b0);        // R7 late data ignored
    mem_rd(16'h8000, "R7 first byte kept");
    mem_wr(16'hBFFF, 8'h22, 8'h22, 1'b0);
    mem_wr(16'h8123, 8'h33, 8'h33, 1'b0);
    mem_wr(16'hC000, 8'hEE, 8'hEE, 1'b0);        // R2 outside
    mem_wr(16'h7FFF, 8'hDD, 8'hDD, 1'b0);        // R2 outside
    mem_rd(16'hC000, "R2 above window");
    mem_rd(16'h7FFF, "R2 below window");
    mem_rd(16'h8000, "R2 low edge");
    mem_rd(16'hBFFF, "R2 high edge");
    mem_rd(16'h8123, "R8 ramdisk");
    mem_rd(16'h8000 + 16'(DEPTH), "R11 alias");

    host_wr(10'h010, 8'h44);
    io_cycle(16'h0003, 1'b1);                    // io-map mode
    mem_rd(16'h8010, "R9 host to bus");
    mem_wr(16'h8000, 8'h55, 8'h55, 1'b0);
    mem_rd(16'h8000, "R8 iomap");
    host_rd(10'h000, "R9 bus to host");
    io_cycle(16'h0002, 1'b1);
    mem_rd(16'h8000, "R8 stores separate");
    io_cycle(16'h0003, 1'b1);

    mem_wr(16'h8020, 8'h66, 8'h66, 1'b1);        // R10 collision
    host_rd(10'h020, "R10 bus wins");
    host_wr(10'h020, 8'h77);
    host_rd(10'h020, "R9 host rewrite");

    io_cycle(16'h0001, 1'b1);                    // back to off
    mem_rd(16'h8000, "R3 off again");
    mem_wr(16'h8030, 8'h12, 8'h12, 1'b0);
    io_cycle(16'h0003, 1'b1);
    host_rd(10'h030, "R3 off write ignored");

    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule